// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits on the CPU side of a bus bridge. It decides whether a CPU memory access that falls in the top 256 MiB of the 32-bit address space should be passed on to the downstream bus. That region is cut into 32 equal chunks of 8 MiB. Each chunk has its own enable bit in a window-enable register. A two-bit gate field in a control register switches the whole forwarding mechanism on or off. The two chunks at the edges of the region, index 0 and index 31, can never be enabled.

Both registers are programmed over a simple register bus. This bus has a write strobe, a 12-bit byte offset and 32-bit write data, plus a read-data output that shows the register at the current offset. The decode path is combinational from the incoming access address and the registered state. For every address the block gives a hit flag and the forwarded address, which passes through unchanged.

Top module: `owin_decoder`

## Requirements
- R1: After reset, the enable register and the control register both read back 0, and no address hits.
- R2: A write to offset 0x060 stores the write data ANDed with 0x7FFFFFFE into the enable register. Bits 0 and 31 therefore always read back 0, and every other bit reads back as written.
- R3: A write to offset 0x038 stores all 32 bits of the write data into the control register, and reading offset 0x038 returns them.
- R4: Forwarding is active only when control bits [8:7] equal 2'b01. The values 2'b00, 2'b10 and 2'b11 suppress every hit, whatever the enable bits hold.
- R5: An address hits exactly when forwarding is active, address bits [31:28] equal 4'hF, and the enable bit selected by address bits [27:23] is set.
- R6: Addresses in chunk 0 (0xF0000000 to 0xF07FFFFF) and in chunk 31 (0xFF800000 to 0xFFFFFFFF) never hit.
- R7: The forwarded address always equals the incoming address.
- R8: A register write takes effect at the clock edge that samples it. During the write cycle the hit flag still follows the old register values, and from the next cycle it follows the new ones.
- R9: A write to any offset other than 0x060 or 0x038 changes neither register. A read at such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr (0 if none) |
| acc_addr | input | 32 | Incoming CPU access address |
| fwd_hit | output | 1 | Access is forwarded downstream |
| fwd_addr | output | 32 | Address presented downstream |

## Verification
Some properties hold on every cycle, and the assertions check them there. The edge chunks never hit. A hit needs the open gate and an address inside the region. At most one chunk matches at a time. The address passes through unchanged. Each register write lands masked, or is ignored at the wrong offset. Other behaviour only the bench scenarios can show. These are the exact hit decision against an independent model over random enable maps and addresses, the rejection of each closed gate value, and the old-then-new timing around a write.

// File: rtl/owin_pkg.sv
package owin_pkg;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int REG_AW      = 12;
  localparam int CHUNK_SHIFT = 23;                 // 8 MiB chunks
  localparam int IDX_W       = 5;
  localparam int NCHUNK      = 1 << IDX_W;
  localparam int TAG_W       = ADDR_W - CHUNK_SHIFT - IDX_W;
  localparam logic [TAG_W-1:0] REGION_TAG = '1;    // top nibble all ones
  localparam logic [REG_AW-1:0] EN_OFFS  = 12'h060;
  localparam logic [REG_AW-1:0] CTL_OFFS = 12'h038;
  localparam int GATE_LSB = 7;
  localparam logic [1:0] GATE_ON = 2'b01;
  // edge chunks (first and last) can never be opened
  localparam logic [NCHUNK-1:0] EN_MASK = {1'b0, {(NCHUNK-2){1'b1}}, 1'b0};

  function automatic logic in_region(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W] == REGION_TAG;
  endfunction

  function automatic logic [IDX_W-1:0] chunk_idx(input logic [ADDR_W-1:0] a);
    return a[CHUNK_SHIFT +: IDX_W];
  endfunction

  function automatic logic gate_open(input logic [DATA_W-1:0] ctl);
    return ctl[GATE_LSB +: 2] == GATE_ON;
  endfunction
endpackage

// File: rtl/owin_regs.sv
module owin_regs
  import owin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCHUNK-1:0] en_q,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] rdata,
  output logic              en_wr,
  output logic              ctl_wr
);
  assign en_wr  = wr && (addr == EN_OFFS);
  assign ctl_wr = wr && (addr == CTL_OFFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (en_wr)  en_q  <= wdata[NCHUNK-1:0] & EN_MASK;
      if (ctl_wr) ctl_q <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == EN_OFFS)       rdata[NCHUNK-1:0] = en_q;
    else if (addr == CTL_OFFS) rdata = ctl_q;
  end
endmodule

// File: rtl/owin_match.sv
module owin_match
  import owin_pkg::*;
(
  input  logic [NCHUNK-1:0] en,
  input  logic [DATA_W-1:0] ctl,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              fwd_on,
  output logic [NCHUNK-1:0] chunk_sel,
  output logic              hit,
  output logic [ADDR_W-1:0] fwd_addr
);
  logic             region_ok;
  logic [IDX_W-1:0] idx;

  assign region_ok = in_region(acc_addr);
  assign idx       = chunk_idx(acc_addr);
  assign fwd_on    = gate_open(ctl);

  for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
    assign chunk_sel[i] = region_ok && (idx == IDX_W'(i)) && en[i];
  end

  assign hit      = fwd_on && (|chunk_sel);
  assign fwd_addr = acc_addr;
endmodule

// File: rtl/owin_decoder.sv
module owin_decoder
  import owin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              fwd_hit,
  output logic [ADDR_W-1:0] fwd_addr
);
  logic [NCHUNK-1:0] en_q;
  logic [DATA_W-1:0] ctl_q;
  logic              en_wr;
  logic              ctl_wr;
  logic              fwd_on;
  logic [NCHUNK-1:0] chunk_sel;

  owin_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .en_q   (en_q),
    .ctl_q  (ctl_q),
    .rdata  (reg_rdata),
    .en_wr  (en_wr),
    .ctl_wr (ctl_wr)
  );

  owin_match u_match (
    .en        (en_q),
    .ctl       (ctl_q),
    .acc_addr  (acc_addr),
    .fwd_on    (fwd_on),
    .chunk_sel (chunk_sel),
    .hit       (fwd_hit),
    .fwd_addr  (fwd_addr)
  );
endmodule

// File: rtl/owin_decoder_chk.sv
module owin_decoder_chk
  import owin_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              fwd_hit,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic [NCHUNK-1:0] en_q,
  input logic [DATA_W-1:0] ctl_q,
  input logic              fwd_on,
  input logic [NCHUNK-1:0] chunk_sel
);
  AST_EDGE_NEVER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (acc_addr[27:23] != 5'd0 && acc_addr[27:23] != 5'd31)); // R6
  AST_HIT_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (ctl_q[8:7] == 2'b01)); // R4
  AST_HIT_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (acc_addr[31:28] == 4'hF && en_q[acc_addr[27:23]])); // R5
  AST_ONE_CHUNK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chunk_sel)); // R5
  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_addr == acc_addr); // R7
  AST_EN_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 12'h060) |=> (en_q == ($past(reg_wdata) & 32'h7FFF_FFFE))); // R2
  AST_CTL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 12'h038) |=> (ctl_q == $past(reg_wdata))); // R3
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 12'h060) |=> $stable(en_q)); // R9
  AST_CTL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 12'h038) |=> $stable(ctl_q)); // R9
  AST_GATE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_hit && !$isunknown(fwd_on)) |-> fwd_on); // R4
endmodule

bind owin_decoder owin_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .acc_addr  (acc_addr),
  .fwd_hit   (fwd_hit),
  .fwd_addr  (fwd_addr),
  .en_q      (en_q),
  .ctl_q     (ctl_q),
  .fwd_on    (fwd_on),
  .chunk_sel (chunk_sel)
);

// File: tb/owin_decoder_tb.sv
module owin_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] acc_addr = '0;
  logic        fwd_hit;
  logic [31:0] fwd_addr;

  int total = 0;
  int bad = 0;
  logic [31:0] m_en = '0;
  logic [31:0] m_ctl = '0;

  always #2.5 clk = ~clk;

  owin_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
    .fwd_hit(fwd_hit), .fwd_addr(fwd_addr)
  );

  // Model: chunk number is the offset from the region base divided by 8 MiB.
  function automatic logic model_hit(logic [31:0] a, logic [31:0] en, logic [31:0] ctl);
    logic [31:0] off;
    int k;
    if (a < 32'hF000_0000) return 1'b0;
    off = a - 32'hF000_0000;
    k = int'(off / 32'h0080_0000);
    if (((ctl >> 7) & 32'h3) != 32'h1) return 1'b0;
    return en[k];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 12'h060) m_en = d & 32'h7FFF_FFFE;
    else if (a == 12'h038) m_ctl = d;
  endtask

  task automatic probe(string req, logic [31:0] a);
    acc_addr = a;
    #0.5;
    check(req, {31'd0, fwd_hit}, {31'd0, model_hit(a, m_en, m_ctl)});
    check("R7", fwd_addr, a);
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1", 12'h060, 32'h0);
    rd("R1", 12'h038, 32'h0);
    probe("R1", 32'hF100_0000);

    // R2 masking
    wr(12'h060, 32'hFFFF_FFFF);
    rd("R2", 12'h060, 32'h7FFF_FFFE);
    wr(12'h060, 32'hA5A5_5A5B);
    rd("R2", 12'h060, 32'h25A5_5A5A);
    // R3 control readback
    wr(12'h038, 32'hDEAD_BEEF);
    rd("R3", 12'h038, 32'hDEAD_BEEF);

    // R4 gate values
    wr(12'h060, 32'hFFFF_FFFF);
    for (int g = 0; g < 4; g++) begin
      wr(12'h038, 32'h0000_0000 | (g << 7));
      probe("R4", 32'hF0C0_1234);
      check("R4", {31'd0, fwd_hit}, {31'd0, (g == 1)});
    end

    // R6 edge chunks with all enabled and gate open
    wr(12'h038, 32'h0000_0080);
    probe("R6", 32'hF000_0000);
    check("R6", {31'd0, fwd_hit}, 32'd0);
    probe("R6", 32'hFFFF_FFFF);
    check("R6", {31'd0, fwd_hit}, 32'd0);
    probe("R5", 32'hF080_0000);
    check("R5", {31'd0, fwd_hit}, 32'd1);
    probe("R5", 32'hFF7F_FFFF);
    check("R5", {31'd0, fwd_hit}, 32'd1);
    probe("R5", 32'hE080_0000);
    check("R5", {31'd0, fwd_hit}, 32'd0);

    // R8 old value during write cycle, new value after
    acc_addr = 32'hF180_0010;                 // chunk 3
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 12'h060; reg_wdata = 32'h0;
    #0.5;
    check("R8", {31'd0, fwd_hit}, 32'd1);
    @(negedge clk);
    reg_wr = 1'b0; m_en = 32'h0;
    #0.5;
    check("R8", {31'd0, fwd_hit}, 32'd0);

    // R9 write to unmapped offset ignored, unmapped read returns 0
    wr(12'h060, 32'h0000_0010);
    wr(12'h064, 32'hFFFF_FFFF);
    wr(12'h03C, 32'h0000_0000);
    rd("R9", 12'h060, 32'h0000_0010);
    rd("R9", 12'h038, 32'h0000_0080);
    rd("R9", 12'h040, 32'h0);
    probe("R9", 32'hF200_0000);               // chunk 4 still open
    check("R9", {31'd0, fwd_hit}, 32'd1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] a;
      op = int'($urandom_range(0, 9));
      if (op == 0) wr(12'h060, $urandom());
      else if (op == 1) begin
        logic [31:0] c;
        c = $urandom();
        if ($urandom_range(0, 2) != 0) c[8:7] = 2'b01;
        wr(12'h038, c);
      end else if (op == 2) wr(12'(($urandom_range(0, 1023)) << 2), $urandom());
      @(negedge clk);
      a = $urandom();
      if ($urandom_range(0, 3) != 0) a[31:28] = 4'hF;
      probe("R5", a);
      if (n % 50 == 0) begin
        rd("R2", 12'h060, m_en);
        rd("R3", 12'h038, m_ctl);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule